// File: doc/BRIEF.md
# Retired-Branch Event Threshold Monitor

This block watches per-cycle retirement strobes from a processor pipeline and raises a trip when monitored branch events become too frequent. A window counter advances on one selectable class of retired instruction. A set of event counters, each fed from a selectable event source, accumulates inside that window. Every counter is compared with its own threshold. The per-counter results are merged either with AND or with OR into a single trip decision.

When the window fills, all counters restart. Mispredicts can be counted in one of two ways: every mispredict in the window, or only an unbroken run of mispredicts. A guest-mode flag can silence the block entirely. A trip can also request a freeze of an external branch trace. Configuration arrives as static input fields driven by a register block outside this one.

Top module: `bev_thresh_mon`

## Requirements
- R1: After reset, `trip` and `freeze_req` are low and all internal counts are zero.
- R2: While `cfg_enable` is low, no trip occurs and every counter is held at zero. Counting after re-enabling starts from zero.
- R3: Counter i counts the source selected by its field `cfg_ctr_src[2i+1:2i]`. The encodings are 00 mispredict (`ret_misp`), 01 retired branch (`ret_br`), 10 retired return (`ret_ret`) and 11 retired indirect branch (`ret_ind`). A counter meets its threshold `cfg_thresh[7i+6:7i]` when its count, including the current cycle's event, is greater than or equal to that threshold. The trip decision is taken only on cycles with `ret_insn` high. A threshold of 0 therefore trips on every retired instruction.
- R4: With `cfg_and_mode` low, one enabled counter (`cfg_ctr_en[i]` high) that meets its threshold is enough to trip.
- R5: With `cfg_and_mode` high, a trip needs every enabled counter to meet its threshold. A disabled counter is ignored and held at zero. With no counter enabled, no trip ever occurs.
- R6: `cfg_win_sel` picks what advances the window. The encodings are 00 `ret_insn`, 01 `ret_br`, 10 `ret_ret` and 11 `ret_ind`.
- R7: A window advance that brings the window count to a value greater than or equal to `cfg_win_size` ends the window. The window and all event counters are cleared at the end of that cycle, after that cycle's trip decision.
- R8: With `cfg_misp_run` low, mispredicts accumulate across the window. With it high, a correctly predicted branch (`ret_br` high, `ret_misp` low) clears every counter whose source is mispredict (00).
- R9: When `cfg_guest_dis` and `guest_mode` are both high, nothing counts, counts are held, and no trip occurs.
- R10: `freeze_req` pulses together with `trip` when `cfg_freeze_en` is high, and stays low otherwise.
- R11: `trip` is a one-cycle pulse in the cycle after the qualifying inputs. After a trip, the window and all event counters restart from zero.
- R12: Event counters saturate at 127 and do not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_insn | input | 1 | An instruction retired this cycle |
| ret_br | input | 1 | A branch retired this cycle |
| ret_ret | input | 1 | A return retired this cycle |
| ret_ind | input | 1 | An indirect branch retired this cycle |
| ret_misp | input | 1 | A retired branch was mispredicted |
| guest_mode | input | 1 | The core is running guest code |
| cfg_enable | input | 1 | Global enable |
| cfg_guest_dis | input | 1 | Silence the block while in guest mode |
| cfg_freeze_en | input | 1 | Let a trip request a trace freeze |
| cfg_and_mode | input | 1 | 1 = AND the counter results, 0 = OR them |
| cfg_misp_run | input | 1 | 1 = count only consecutive mispredicts |
| cfg_win_sel | input | 2 | Window advance class |
| cfg_win_size | input | 10 | Window length |
| cfg_ctr_en | input | 2 | Per-counter enable |
| cfg_ctr_src | input | 4 | Per-counter event source, 2 bits each |
| cfg_thresh | input | 14 | Per-counter threshold, 7 bits each |
| trip | output | 1 | Threshold trip pulse |
| freeze_req | output | 1 | Trace-freeze request pulse |

## Verification
The hardest state to reach is a counter sitting at saturation while the trip stays low. In OR mode any counter that high would already have tripped. The bench reaches this state in AND mode: one counter is driven with 130 branches, past saturation, while the second counter's return events stay below its threshold. Two returns then complete the trip. A wrapping counter would have fallen to 2, which is below its threshold of 5, so it would not trip. Randomised phases with small windows and thresholds also make window ends, trips and run-clearing branches land on the same cycle.

// File: rtl/bev_pkg.sv
package bev_pkg;
  // retirement class used to advance the window (R6)
  typedef enum logic [1:0] {
    WIN_INSN = 2'b00,
    WIN_BR   = 2'b01,
    WIN_RET  = 2'b10,
    WIN_IND  = 2'b11
  } win_sel_e;

  // event source feeding one event counter (R3)
  typedef enum logic [1:0] {
    SRC_MISP = 2'b00,
    SRC_BR   = 2'b01,
    SRC_RET  = 2'b10,
    SRC_IND  = 2'b11
  } ev_src_e;

  // picks one of four strobes by a 2-bit code
  function automatic logic pick4(input logic [1:0] code, input logic [3:0] strobes);
    return strobes[code];
  endfunction
endpackage

// File: rtl/bev_window.sv
module bev_window #(
  parameter int WW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [WW-1:0] size,
  output logic          win_end
);
  logic [WW-1:0] cnt;
  logic [WW:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + (WW+1)'(1);
  assign win_end = tick && (cnt_inc >= {1'b0, size});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clr || win_end)  cnt <= '0;
    else if (tick)            cnt <= cnt_inc[WW-1:0];
  end

  // R7
  win_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (cnt == '0));

  // R9
  win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt));
endmodule

// File: rtl/bev_evt_ctr.sv
module bev_evt_ctr #(
  parameter int TW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic          run_clr,
  input  logic [TW-1:0] thresh,
  output logic          met
);
  localparam logic [TW-1:0] CNT_TOP = '1;

  logic [TW-1:0] cnt;
  logic [TW-1:0] cnt_nxt;

  function automatic logic [TW-1:0] sat_inc(input logic [TW-1:0] v);
    return (v == CNT_TOP) ? v : v + TW'(1);
  endfunction

  always_comb begin
    if (run_clr)   cnt_nxt = '0;
    else if (inc)  cnt_nxt = sat_inc(cnt);
    else           cnt_nxt = cnt;
  end

  assign met = (cnt_nxt >= thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else           cnt <= cnt_nxt;
  end

  // R11
  ctr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  // R12
  ctr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_TOP && inc && !run_clr && !clr) |=> (cnt == CNT_TOP));

  // R8
  ctr_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_clr |=> (cnt == '0));
endmodule

// File: rtl/bev_thresh_mon.sv
module bev_thresh_mon #(
  parameter int WW = 10,
  parameter int TW = 7,
  parameter int NC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ret_insn,
  input  logic             ret_br,
  input  logic             ret_ret,
  input  logic             ret_ind,
  input  logic             ret_misp,
  input  logic             guest_mode,
  input  logic             cfg_enable,
  input  logic             cfg_guest_dis,
  input  logic             cfg_freeze_en,
  input  logic             cfg_and_mode,
  input  logic             cfg_misp_run,
  input  logic [1:0]       cfg_win_sel,
  input  logic [WW-1:0]    cfg_win_size,
  input  logic [NC-1:0]    cfg_ctr_en,
  input  logic [2*NC-1:0]  cfg_ctr_src,
  input  logic [NC*TW-1:0] cfg_thresh,
  output logic             trip,
  output logic             freeze_req
);
  import bev_pkg::*;

  logic          active;
  logic          win_tick;
  logic          win_end;
  logic          cond;
  logic          trip_now;
  logic          run_brk;
  logic [NC-1:0] ctr_met;
  logic [NC-1:0] ctr_inc;
  logic [NC-1:0] ctr_run_clr;
  logic [NC-1:0] ctr_clr;

  function automatic logic combine(input logic [NC-1:0] en, input logic [NC-1:0] met,
                                   input logic and_m);
    if (en == '0) return 1'b0;
    if (and_m)    return ((met | ~en) == '1);
    return |(met & en);
  endfunction

  assign active   = cfg_enable && !(cfg_guest_dis && guest_mode);
  assign win_tick = active && pick4(cfg_win_sel, {ret_ind, ret_ret, ret_br, ret_insn});
  assign run_brk  = active && cfg_misp_run && ret_br && !ret_misp;
  assign cond     = combine(cfg_ctr_en, ctr_met, cfg_and_mode);
  assign trip_now = active && ret_insn && cond;

  bev_window #(.WW(WW)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!cfg_enable || trip_now),
    .tick    (win_tick),
    .size    (cfg_win_size),
    .win_end (win_end)
  );

  for (genvar gi = 0; gi < NC; gi++) begin : g_ctr
    logic [1:0] src;
    assign src = cfg_ctr_src[2*gi +: 2];
    assign ctr_inc[gi] = active &&
                         pick4(src, {ret_ind, ret_ret, ret_br, ret_misp});
    assign ctr_run_clr[gi] = run_brk && (ev_src_e'(src) == SRC_MISP);
    assign ctr_clr[gi] = !cfg_enable || !cfg_ctr_en[gi] || trip_now || win_end;

    bev_evt_ctr #(.TW(TW)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (ctr_clr[gi]),
      .inc     (ctr_inc[gi]),
      .run_clr (ctr_run_clr[gi]),
      .thresh  (cfg_thresh[TW*gi +: TW]),
      .met     (ctr_met[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip       <= 1'b0;
      freeze_req <= 1'b0;
    end else begin
      trip       <= trip_now;
      freeze_req <= trip_now && cfg_freeze_en;
    end
  end

  // R2
  off_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !trip);

  // R9
  guest_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_guest_dis && guest_mode) |=> !trip);

  // R10
  freeze_with_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_req |-> trip);

  // R3
  trip_on_insn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_insn |=> !trip);

  // R5
  none_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ctr_en == '0) |=> !trip);
endmodule

// File: tb/tb_bev_thresh_mon.sv
module tb_bev_thresh_mon;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ret_insn = 0, ret_br = 0, ret_ret = 0, ret_ind = 0, ret_misp = 0, guest_mode = 0;
  logic cfg_enable = 0, cfg_guest_dis = 0, cfg_freeze_en = 0, cfg_and_mode = 0, cfg_misp_run = 0;
  logic [1:0]  cfg_win_sel = 2'b00;
  logic [9:0]  cfg_win_size = 10'd1023;
  logic [1:0]  cfg_ctr_en = 2'b00;
  logic [3:0]  cfg_ctr_src = 4'b0000;
  logic [13:0] cfg_thresh = {7'd127, 7'd127};
  logic trip, freeze_req;

  int checks = 0;
  int errors = 0;
  int m_win = 0;
  int m_cnt [2] = '{0, 0};
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bev_thresh_mon dut (
    .clk(clk), .rst_n(rst_n), .ret_insn(ret_insn), .ret_br(ret_br), .ret_ret(ret_ret),
    .ret_ind(ret_ind), .ret_misp(ret_misp), .guest_mode(guest_mode),
    .cfg_enable(cfg_enable), .cfg_guest_dis(cfg_guest_dis), .cfg_freeze_en(cfg_freeze_en),
    .cfg_and_mode(cfg_and_mode), .cfg_misp_run(cfg_misp_run), .cfg_win_sel(cfg_win_sel),
    .cfg_win_size(cfg_win_size), .cfg_ctr_en(cfg_ctr_en), .cfg_ctr_src(cfg_ctr_src),
    .cfg_thresh(cfg_thresh), .trip(trip), .freeze_req(freeze_req)
  );

  function automatic bit strobe_of(input int code, input bit a0, a1, a2, a3);
    case (code)
      0: return a0;
      1: return a1;
      2: return a2;
      default: return a3;
    endcase
  endfunction

  task automatic check(input bit got, input bit exp, input string what, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  // one clock: drive strobes, step the reference model, compare both outputs
  task automatic cyc(input bit i, b, r, n, m, input string tag);
    bit act, tick, wend, exp_trip, cond;
    int nxt [2];
    int nen, nmet;
    @(negedge clk);
    ret_insn = i; ret_br = b; ret_ret = r; ret_ind = n; ret_misp = m;
    act = cfg_enable && !(cfg_guest_dis && guest_mode);
    nen = 0; nmet = 0;
    for (int k = 0; k < 2; k++) begin
      int src = int'(cfg_ctr_src[2*k +: 2]);
      nxt[k] = m_cnt[k];
      if (act) begin
        if (cfg_misp_run && src == 0 && b && !m) nxt[k] = 0;
        else if (strobe_of(src, m, b, r, n)) nxt[k] = (nxt[k] >= 127) ? 127 : nxt[k] + 1;
      end
      if (cfg_ctr_en[k]) begin
        nen++;
        if (nxt[k] >= int'(cfg_thresh[7*k +: 7])) nmet++;
      end
    end
    cond = cfg_and_mode ? (nen > 0 && nmet == nen) : (nmet > 0);
    exp_trip = act && i && cond;
    tick = act && strobe_of(int'(cfg_win_sel), i, b, r, n);
    wend = tick && (m_win + 1 >= int'(cfg_win_size));
    if (!cfg_enable || exp_trip) begin
      m_win = 0; m_cnt[0] = 0; m_cnt[1] = 0;
    end else begin
      m_win = wend ? 0 : (tick ? m_win + 1 : m_win);
      for (int k = 0; k < 2; k++) m_cnt[k] = (!cfg_ctr_en[k] || wend) ? 0 : nxt[k];
    end
    @(posedge clk);
    #1;
    check(trip, exp_trip, "trip", tag);
    check(freeze_req, exp_trip && cfg_freeze_en, "freeze_req", tag);
  endtask

  task automatic flush();
    bit keep = cfg_enable;
    cfg_enable = 0;
    cyc(0, 0, 0, 0, 0, "R2");
    cfg_enable = keep;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check(trip, 1'b0, "trip in reset", "R1");
    check(freeze_req, 1'b0, "freeze in reset", "R1");
    @(negedge clk); rst_n = 1;
    cyc(1, 0, 0, 0, 0, "R1");

    // R2: disabled block never trips even with threshold 0
    cfg_ctr_en = 2'b01; cfg_thresh = {7'd127, 7'd0};
    repeat (4) cyc(1, 1, 0, 0, 1, "R2");
    cfg_enable = 1;
    // R3: threshold 0 trips on every retired instruction
    repeat (3) cyc(1, 0, 0, 0, 0, "R3");
    cyc(0, 0, 0, 0, 0, "R3");
    // R3 / R11: branch counter with threshold 3
    cfg_ctr_src = 4'b0001; cfg_thresh = {7'd127, 7'd3}; flush();
    for (int k = 0; k < 8; k++) cyc(1, (k % 2) == 1, 0, 0, 0, "R11");
    cfg_ctr_src = 4'b0011; flush();
    for (int k = 0; k < 5; k++) cyc(1, 1, 0, 1, 0, "R3");
    cfg_ctr_src = 4'b0010; flush();
    for (int k = 0; k < 5; k++) cyc(1, 1, 1, 0, 0, "R3");

    // R4: OR mode, counter 1 alone reaches threshold
    cfg_ctr_en = 2'b11; cfg_ctr_src = 4'b0110; cfg_thresh = {7'd2, 7'd9}; flush();
    for (int k = 0; k < 4; k++) cyc(1, 1, 0, 0, 0, "R4");
    // R5: AND mode, both needed; then counter 0 disabled
    cfg_and_mode = 1; cfg_thresh = {7'd2, 7'd3}; flush();
    for (int k = 0; k < 6; k++) cyc(1, k < 3, k >= 3, 0, 0, "R5");
    cfg_ctr_en = 2'b10; flush();
    for (int k = 0; k < 4; k++) cyc(1, 1, 0, 0, 0, "R5");
    cfg_ctr_en = 2'b00; flush();
    for (int k = 0; k < 3; k++) cyc(1, 1, 1, 1, 1, "R5");
    cfg_and_mode = 0;

    // R6 / R7: windows per class clear a counter before threshold
    cfg_ctr_en = 2'b01; cfg_ctr_src = 4'b0000; cfg_thresh = {7'd127, 7'd3};
    cfg_win_size = 10'd2;
    for (int s = 0; s < 4; s++) begin
      cfg_win_sel = 2'(s); flush();
      for (int k = 0; k < 10; k++) cyc(1, 1, (k % 3) == 0, (k % 2) == 0, 1, "R6");
    end
    cfg_win_sel = 2'b01; cfg_win_size = 10'd0; flush();
    for (int k = 0; k < 4; k++) cyc(1, 1, 0, 0, 1, "R7");
    cfg_win_size = 10'd1023;

    // R8: window vs consecutive mispredict counting
    for (int mode = 0; mode < 2; mode++) begin
      cfg_misp_run = mode[0]; flush();
      for (int k = 0; k < 8; k++) cyc(1, 1, 0, 0, (k % 3) != 2, "R8");
    end
    cfg_misp_run = 0;

    // R9: guest silence
    cfg_guest_dis = 1; guest_mode = 1; cfg_thresh = {7'd127, 7'd0}; flush();
    repeat (3) cyc(1, 1, 0, 0, 1, "R9");
    guest_mode = 0;
    repeat (2) cyc(1, 0, 0, 0, 0, "R9");
    cfg_guest_dis = 0;

    // R10: freeze request
    cfg_freeze_en = 1;
    repeat (2) cyc(1, 0, 0, 0, 0, "R10");
    cfg_freeze_en = 0;
    cyc(1, 0, 0, 0, 0, "R10");

    // R12: saturation under AND mode
    cfg_and_mode = 1; cfg_ctr_en = 2'b11; cfg_ctr_src = 4'b0110;
    cfg_thresh = {7'd5, 7'd2}; cfg_win_sel = 2'b10; flush();
    repeat (130) cyc(1, 1, 0, 0, 0, "R12");
    repeat (2) cyc(1, 0, 1, 0, 0, "R12");
    cfg_and_mode = 0;

    // mixed random phases
    for (int p = 0; p < 20; p++) begin
      cfg_win_sel = 2'($urandom_range(0, 3)); cfg_win_size = 10'($urandom_range(0, 9));
      cfg_ctr_en = 2'($urandom_range(0, 3)); cfg_ctr_src = 4'($urandom_range(0, 15));
      cfg_thresh = {7'($urandom_range(0, 6)), 7'($urandom_range(0, 6))};
      cfg_and_mode = 1'($urandom_range(0, 1)); cfg_misp_run = 1'($urandom_range(0, 1));
      cfg_guest_dis = 1'($urandom_range(0, 1)); cfg_freeze_en = 1'($urandom_range(0, 1));
      cfg_enable = ($urandom_range(0, 7) != 0);
      for (int k = 0; k < 150; k++) begin
        bit b = 1'($urandom_range(0, 1));
        guest_mode = ($urandom_range(0, 5) == 0);
        cyc(b | 1'($urandom_range(0, 1)), b, b & 1'($urandom_range(0, 1)),
            b & 1'($urandom_range(0, 1)), b & 1'($urandom_range(0, 1)), "R4");
      end
    end
    finish_run();
  end
endmodule